// File: doc/BRIEF.md
# Segmented Digit-Serial Binary Field Multiplier

This block multiplies two elements of GF(2^M) held in polynomial basis and reduces the product modulo a fixed field polynomial. One operand arrives as a whole M-bit word. The other arrives as a stream of W-bit digits, one per clock, with the highest-weight digit first. The default configuration is M = 163 and W = 41, which gives S = ceil(M/W) = 4 digits per product. The default field polynomial is x^163 + x^7 + x^6 + x^3 + 1.

Every digit is multiplied by the word operand in N narrower slices. Slice widths differ by at most one bit. The slice products are XORed together and captured in a segment register. A second stage then takes the running accumulator, shifts it up by W, adds the captured product, and reduces the sum bit by bit from the top. The reduced value goes into the accumulator, and on the last digit it also goes into the result register. When a new product starts, a multiplexer selects zero in place of the accumulator feedback, so no clearing cycle is needed. A new product can therefore enter in the cycle right after the previous product's last digit.

A control state machine has two states. `ST_IDLE` waits for `start`. `ST_FEED` counts the remaining digits. The transition `IDLE->FEED` happens when `start` is taken. The transition `FEED->FEED` happens while digits remain. The transition `FEED->IDLE` happens on the last digit. When S = 1, a taken start stays in `ST_IDLE`.

Top module: `gf_segmul`

## Requirements
- R1: In the done cycle, `result` equals a·b mod P(x). Here a is `a_word` at the start edge, b is the multiplier assembled from the digit stream, and P(x) is the field polynomial given by parameter `POLY`. Bit i of each word is the coefficient of x^i. This includes zero and all-ones operands.
- R2: Digits are taken most significant first. The digit presented in the start cycle holds multiplier bits [S·W-1 : (S-1)·W], where bits at M and above are zero. Each following cycle presents the next lower W bits, down to bits [W-1:0].
- R3: If `start` is sampled at rising edge k and the block is idle, `done` is high for exactly the one cycle that follows edge k+S. It is low in every cycle between the start and that cycle. The product therefore spans S+2 cycles, counting both the start cycle and the done cycle.
- R4: `result` keeps its value in every cycle in which `done` is low.
- R5: A start sampled at edge k+S, the edge right after the previous product's last digit, is accepted. That product completes per R1 and R3, with no residue from the previous product. The previous product's result and `done` are not disturbed.
- R6: A `start` sampled at edges k+1 through k+S-1, while digits are still being taken, is ignored. No extra `done` pulse appears and the running result is unaffected.
- R7: `a_word` is sampled only at the edge that takes `start`. Changing it in later cycles of the same product has no effect on the result.
- R8: While `rst` (synchronous, active high) is sampled high, the next cycle shows `done` = 0 and `result` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a product; taken only when idle |
| a_word | input | M | Full-width operand, sampled with start |
| digit | input | W | Multiplier digit, most significant first |
| result | output | M | Reduced product, held until the next done |
| done | output | 1 | One-cycle pulse when result is new |

## Verification
Each product is driven cycle by cycle, with inputs changed on falling edges. If the start edge is k, `done` must be low after edges k through k+S-1 and high after edge k+S. In that same cycle `result` must match a bit-serial shift-and-reduce model. The checks sample at the falling edge after each rising edge, so the expected cycle is fixed by counting the segment and accumulator registers. In back-to-back runs both pulses are checked, at k+S and k+2S. In the hold, ignored-start and operand-change scenarios, cycles are counted the same way and `result` is compared after the exact edge where a stray change would first appear.

// File: rtl/gfsm_pkg.sv
package gfsm_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FEED = 1'b1
    } ctl_state_e;

    // width of slice i when w digit bits are split into n nearly equal slices
    function automatic int slice_width(input int w, input int n, input int i);
        return (w / n) + ((i < (w % n)) ? 1 : 0);
    endfunction

    // lowest digit bit covered by slice i
    function automatic int slice_base(input int w, input int n, input int i);
        int acc;
        acc = 0;
        for (int k = 0; k < i; k++) begin
            acc += slice_width(w, n, k);
        end
        return acc;
    endfunction

endpackage

// File: rtl/gfsm_ctrl.sv
module gfsm_ctrl
    import gfsm_pkg::*;
#(
    parameter int S = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic take,
    output logic first,
    output logic last
);
    localparam int CW = (S < 2) ? 1 : $clog2(S + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(S - 1);

    ctl_state_e     state_q, state_n;
    logic [CW-1:0]  cnt_q, cnt_n;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // next state and per-cycle outputs
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        take    = 1'b0;
        first   = 1'b0;
        last    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    take  = 1'b1;
                    first = 1'b1;
                    last  = (S == 1);
                    if (S > 1) begin
                        state_n = ST_FEED;
                        cnt_n   = CW'(1);
                    end
                end
            end
            ST_FEED: begin
                take = 1'b1;
                if (cnt_q == LAST_IDX) begin
                    last    = 1'b1;
                    state_n = ST_IDLE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    // R6
    feed_adv_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FEED && cnt_q != LAST_IDX)
            |=> (state_q == ST_FEED && cnt_q == CW'($past(cnt_q) + CW'(1))));

    // R5
    idle_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FEED && cnt_q == LAST_IDX) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/gfsm_seg_stage.sv
module gfsm_seg_stage
    import gfsm_pkg::*;
#(
    parameter int M  = 163,
    parameter int W  = 41,
    parameter int N  = 3,
    parameter int PW = M + W - 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic          first,
    input  logic          last,
    input  logic [M-1:0]  a_in,
    input  logic [W-1:0]  digit,
    output logic [PW-1:0] seg_q,
    output logic          s1_vld,
    output logic          s1_first,
    output logic          s1_last
);
    logic [M-1:0]          a_q;
    logic [M-1:0]          a_use;
    logic [N-1:0][PW-1:0]  parts;
    logic [PW-1:0]         sum;

    assign a_use = first ? a_in : a_q;

    for (genvar g = 0; g < N; g++) begin : g_slice
        localparam int SW  = slice_width(W, N, g);
        localparam int OFF = slice_base(W, N, g);
        logic [PW-1:0] part;
        always_comb begin
            part = '0;
            for (int k = 0; k < SW; k++) begin
                if (digit[OFF + k]) begin
                    part = part ^ (PW'(a_use) << (OFF + k));
                end
            end
        end
        assign parts[g] = part;
    end

    always_comb begin
        sum = '0;
        for (int g = 0; g < N; g++) begin
            sum = sum ^ parts[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q      <= '0;
            seg_q    <= '0;
            s1_vld   <= 1'b0;
            s1_first <= 1'b0;
            s1_last  <= 1'b0;
        end else begin
            if (first) begin
                a_q <= a_in;
            end
            s1_vld   <= take;
            s1_first <= first;
            s1_last  <= last;
            if (take) begin
                seg_q <= sum;
            end
        end
    end

    // R7
    a_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !first |=> $stable(a_q));

endmodule

// File: rtl/gfsm_red_stage.sv
module gfsm_red_stage #(
    parameter int         M    = 163,
    parameter int         W    = 41,
    parameter int         PW   = M + W - 1,
    parameter logic [M:0] POLY = {1'b1, M'(8'hC9)}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] seg_q,
    input  logic          s1_vld,
    input  logic          s1_first,
    input  logic          s1_last,
    output logic [M-1:0]  result,
    output logic          done
);
    localparam int VW = M + W;

    logic [M-1:0]  acc_q;
    logic [M-1:0]  fb;
    logic [VW-1:0] wide;
    logic [M-1:0]  reduced;

    function automatic logic [M-1:0] fold(input logic [VW-1:0] v_in);
        logic [VW-1:0] v;
        v = v_in;
        for (int i = VW - 1; i >= M; i--) begin
            if (v[i]) begin
                v = v ^ (VW'(POLY) << (i - M));
            end
        end
        return v[M-1:0];
    endfunction

    // zero-select on the first digit replaces a clearing cycle
    assign fb      = s1_first ? '0 : acc_q;
    assign wide    = {fb, {W{1'b0}}} ^ VW'(seg_q);
    assign reduced = fold(wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= s1_vld && s1_last;
            if (s1_vld) begin
                acc_q <= reduced;
                if (s1_last) begin
                    result <= reduced;
                end
            end
        end
    end

    // R3
    done_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && s1_last) |=> done);

endmodule

// File: rtl/gf_segmul.sv
module gf_segmul #(
    parameter int         M    = 163,
    parameter int         W    = 41,
    parameter int         N    = 3,
    parameter logic [M:0] POLY = {1'b1, M'(8'hC9)}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [M-1:0] a_word,
    input  logic [W-1:0] digit,
    output logic [M-1:0] result,
    output logic         done
);
    localparam int S  = (M + W - 1) / W;
    localparam int PW = M + W - 1;

    logic          take, first, last;
    logic [PW-1:0] seg_q;
    logic          s1_vld, s1_first, s1_last;

    gfsm_ctrl #(.S(S)) ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .take  (take),
        .first (first),
        .last  (last)
    );

    gfsm_seg_stage #(.M(M), .W(W), .N(N), .PW(PW)) seg_i (
        .clk      (clk),
        .rst      (rst),
        .take     (take),
        .first    (first),
        .last     (last),
        .a_in     (a_word),
        .digit    (digit),
        .seg_q    (seg_q),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last)
    );

    gfsm_red_stage #(.M(M), .W(W), .PW(PW), .POLY(POLY)) red_i (
        .clk      (clk),
        .rst      (rst),
        .seg_q    (seg_q),
        .s1_vld   (s1_vld),
        .s1_first (s1_first),
        .s1_last  (s1_last),
        .result   (result),
        .done     (done)
    );

    // R4
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (S > 1 && done) |=> !done);

    // R8
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!done && result == '0));

endmodule

// File: tb/gf_segmul_tb_top.sv
module gf_segmul_tb_top;
    localparam int         M    = 163;
    localparam int         W    = 41;
    localparam int         N    = 3;
    localparam int         S    = (M + W - 1) / W;
    localparam logic [M:0] POLY = {1'b1, M'(8'hC9)};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [M-1:0] a_word = '0;
    logic [W-1:0] digit = '0;
    logic [M-1:0] result;
    logic         done;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    gf_segmul #(.M(M), .W(W), .N(N), .POLY(POLY)) dut_i (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .a_word (a_word),
        .digit  (digit),
        .result (result),
        .done   (done)
    );

    function automatic logic [M-1:0] ref_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r;
        logic         top;
        r = '0;
        for (int i = M - 1; i >= 0; i--) begin
            top = r[M-1];
            r   = r << 1;
            if (top) r = r ^ POLY[M-1:0];
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    function automatic logic [W-1:0] dig_of(input logic [M-1:0] b, input int j);
        logic [S*W-1:0] bp;
        bp = (S*W)'(b);
        return W'(bp >> ((S - 1 - j) * W));
    endfunction

    function automatic logic [M-1:0] rnd_word();
        logic [M-1:0] v;
        v = '0;
        for (int i = 0; i < (M + 31) / 32; i++) begin
            v = (v << 32) | M'($urandom);
        end
        return v;
    endfunction

    task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // cycle-by-cycle run of one or two products; the second starts at cycle S
    task automatic run_pair(input string req, input logic two,
                            input logic [M-1:0] a1, input logic [M-1:0] b1,
                            input logic [M-1:0] a2, input logic [M-1:0] b2,
                            input logic noise);
        int last_c;
        last_c = two ? 2 * S + 1 : S + 1;
        for (int c = 0; c <= last_c; c++) begin
            if (c < S) begin
                start  = (c == 0) || noise;
                a_word = (c == 0) ? a1 : ~a1;
                digit  = dig_of(b1, c);
            end else if (two && c < 2 * S) begin
                start  = (c == S) || noise;
                a_word = (c == S) ? a2 : ~a2;
                digit  = dig_of(b2, c - S);
            end else begin
                start  = 1'b0;
                digit  = '0;
            end
            @(negedge clk);
            // done is due after edge S (and 2S for the second product)
            check({req, " R3 done timing"}, M'(done),
                  M'((c == S) || (two && c == 2 * S)));
            if (c == S) check({req, " R1 first result"}, result, ref_mul(a1, b1));
            if (two && c == 2 * S) check({req, " R5 second result"}, result, ref_mul(a2, b2));
        end
    endtask

    task automatic t_reset();
        check("R8 reset done", M'(done), '0);
        check("R8 reset result", result, '0);
    endtask

    task automatic t_corners();
        logic [M-1:0] ones;
        ones = '1;
        run_pair("zero", 1'b0, '0, rnd_word(), '0, '0, 1'b0);
        run_pair("ones", 1'b0, ones, ones, '0, '0, 1'b0);
        run_pair("one", 1'b0, rnd_word(), M'(1), '0, '0, 1'b0);
        // R2: top multiplier bit alone lands in the first digit
        run_pair("R2 msd", 1'b0, rnd_word(), M'(1) << (M - 1), '0, '0, 1'b0);
        run_pair("R2 lsd", 1'b0, rnd_word(), M'(1) << (W - 1), '0, '0, 1'b0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 16; i++) begin
            run_pair("R1 random", 1'b0, rnd_word(), rnd_word(), '0, '0, 1'b0);
        end
    endtask

    task automatic t_back2back();
        for (int i = 0; i < 4; i++) begin
            run_pair("R5 overlap", 1'b1, rnd_word(), rnd_word(), rnd_word(), rnd_word(), 1'b0);
        end
    endtask

    // R6 and R7: start held high and a_word inverted during feed cycles
    task automatic t_noise();
        for (int i = 0; i < 4; i++) begin
            run_pair("R6 R7 noise", 1'b0, rnd_word(), rnd_word(), '0, '0, 1'b1);
        end
    endtask

    task automatic t_hold();
        logic [M-1:0] a, b;
        a = rnd_word();
        b = rnd_word();
        run_pair("R4 prep", 1'b0, a, b, '0, '0, 1'b0);
        for (int c = 0; c < 5; c++) begin
            digit  = W'($urandom);
            a_word = rnd_word();
            @(negedge clk);
            check("R4 hold result", result, ref_mul(a, b));
            check("R4 hold done", M'(done), '0);
        end
        digit = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_corners();
        t_random();
        t_back2back();
        t_noise();
        t_hold();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule